// File: doc/BRIEF.md
# Conditional Move and Set Unit

This unit performs the data side of conditional-move and set-on-condition operations for an execution pipeline. On every clock it takes a source value, the destination's current value, a byte-size field, an operation code, a 3-bit condition code and the four status flags N, C, Z and V. It produces the destination's new value, a write strobe and the new Z and N flags. Each result is registered, so it appears one cycle after the inputs.

A move keeps the low (size + 1) bytes of the source and zero-extends them. It then derives Z and N from that narrowed value. A conditional move does this only when its condition is true. A set-on-condition writes 0 or 1 and leaves the flags alone. Operand addressing and arithmetic happen elsewhere. This unit only decides what gets written and with which flags.

Top module: `cmov_set_unit`

## Requirements
- R1: The condition code selects a flag with bits [2:1] (00 = N, 01 = C, 10 = Z, 11 = V). Bit 0 picks the polarity: 0 means "flag set" and 1 means "flag clear". This gives eight conditions.
- R2: A conditional move (op 01) whose condition is false deasserts the write strobe. It returns the destination input unchanged, and Z and N equal their inputs.
- R3: A move keeps source bytes 0 to s, where s is the size field clamped to DATA_W/8 − 1, and clears every higher byte.
- R4: A move that writes sets Z to 1 exactly when its masked result is zero.
- R5: A move that writes sets N to bit ((s + 1)·8 − 1) of the masked result.
- R6: An unconditional move (op 00) always asserts the write strobe and writes the masked source, whatever the flags are.
- R7: A set-on-condition (op 10) always asserts the write strobe. It writes 1 when the condition holds and 0 otherwise, and Z and N equal their inputs.
- R8: Op code 11 asserts no write. It returns the destination input, and Z and N equal their inputs.
- R9: Outputs are registered with one cycle of latency. A synchronous active-high reset clears the data, the strobe and both flags to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| src_i | input | DATA_W | Source value |
| dst_i | input | DATA_W | Current destination value |
| size_i | input | SIZE_W | Size field; width in bytes is the field value plus one |
| op_i | input | 2 | 00 move, 01 conditional move, 10 set-on-condition, 11 none |
| cond_i | input | 3 | Condition code |
| flag_n_i | input | 1 | Negative flag |
| flag_c_i | input | 1 | Carry flag |
| flag_z_i | input | 1 | Zero flag |
| flag_v_i | input | 1 | Overflow flag |
| dst_o | output | DATA_W | New destination value |
| wr_o | output | 1 | Destination write strobe |
| z_o | output | 1 | New Z flag |
| n_o | output | 1 | New N flag |

## Verification
The unit holds no state beyond its output register, so an internal fault shows up on the ports one cycle after the operation that triggers it. The output never depends on earlier operations. A wrong flag selection or polarity shows up as a strobe or a 0/1 value that disagrees with the flags. A wrong byte boundary shows up as stray upper bytes, or as an N taken from the wrong bit. A wrong pass-through on a suppressed move shows up as a changed destination or changed flags.

// File: rtl/cmov_pkg.sv
package cmov_pkg;

    typedef enum logic [1:0] {
        OP_MOVE  = 2'b00,
        OP_CMOVE = 2'b01,
        OP_SET   = 2'b10,
        OP_NONE  = 2'b11
    } op_e;

    typedef enum logic [1:0] {
        SEL_N = 2'b00,
        SEL_C = 2'b01,
        SEL_Z = 2'b10,
        SEL_V = 2'b11
    } flag_sel_e;

    typedef struct packed {
        logic n;
        logic c;
        logic z;
        logic v;
    } flags_t;

    // R1: bits [2:1] pick the flag, bit 0 inverts the test
    function automatic logic cond_true(input logic [2:0] cc, input flags_t f);
        logic picked;
        case (flag_sel_e'(cc[2:1]))
            SEL_N:   picked = f.n;
            SEL_C:   picked = f.c;
            SEL_Z:   picked = f.z;
            default: picked = f.v;
        endcase
        return picked ^ cc[0];
    endfunction

endpackage

// File: rtl/cmov_cond_eval.sv
module cmov_cond_eval
    import cmov_pkg::*;
(
    input  logic [2:0] cond_i,
    input  flags_t     flags_i,
    output logic       hit_o
);
    always_comb hit_o = cond_true(cond_i, flags_i);
endmodule

// File: rtl/cmov_size_mask.sv
module cmov_size_mask #(
    parameter int DATA_W = 64,
    parameter int SIZE_W = 3
) (
    input  logic [DATA_W-1:0] src_i,
    input  logic [SIZE_W-1:0] size_i,
    output logic [DATA_W-1:0] data_o,
    output logic              zero_o,
    output logic              neg_o
);
    localparam int              BYTES  = DATA_W / 8;
    localparam logic [SIZE_W-1:0] MAX_SZ = SIZE_W'(BYTES - 1);

    logic [SIZE_W-1:0] sz_eff;
    logic [BYTES-1:0]  top_hit;

    always_comb sz_eff = (size_i > MAX_SZ) ? MAX_SZ : size_i;

    for (genvar b = 0; b < BYTES; b++) begin : g_byte
        assign data_o[b*8 +: 8] = (SIZE_W'(b) <= sz_eff) ? src_i[b*8 +: 8] : 8'h00;
        assign top_hit[b]       = (SIZE_W'(b) == sz_eff) & src_i[b*8 + 7];
    end

    always_comb begin
        zero_o = (data_o == '0);
        neg_o  = |top_hit;
    end
endmodule

// File: rtl/cmov_set_unit.sv
module cmov_set_unit
    import cmov_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int SIZE_W = 3
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [DATA_W-1:0] src_i,
    input  logic [DATA_W-1:0] dst_i,
    input  logic [SIZE_W-1:0] size_i,
    input  logic [1:0]        op_i,
    input  logic [2:0]        cond_i,
    input  logic              flag_n_i,
    input  logic              flag_c_i,
    input  logic              flag_z_i,
    input  logic              flag_v_i,
    output logic [DATA_W-1:0] dst_o,
    output logic              wr_o,
    output logic              z_o,
    output logic              n_o
);
    flags_t            flags;
    logic              hit;
    logic [DATA_W-1:0] mv_data;
    logic              mv_zero;
    logic              mv_neg;
    op_e               op;
    logic [DATA_W-1:0] nxt_data;
    logic              nxt_wr;
    logic              nxt_z;
    logic              nxt_n;

    assign flags = '{n: flag_n_i, c: flag_c_i, z: flag_z_i, v: flag_v_i};
    assign op    = op_e'(op_i);

    cmov_cond_eval u_cond (
        .cond_i  (cond_i),
        .flags_i (flags),
        .hit_o   (hit)
    );

    cmov_size_mask #(.DATA_W(DATA_W), .SIZE_W(SIZE_W)) u_mask (
        .src_i  (src_i),
        .size_i (size_i),
        .data_o (mv_data),
        .zero_o (mv_zero),
        .neg_o  (mv_neg)
    );

    always_comb begin
        nxt_data = dst_i;
        nxt_wr   = 1'b0;
        nxt_z    = flag_z_i;
        nxt_n    = flag_n_i;
        case (op)
            OP_MOVE, OP_CMOVE: begin
                if (op == OP_MOVE || hit) begin
                    nxt_data = mv_data;
                    nxt_wr   = 1'b1;
                    nxt_z    = mv_zero;
                    nxt_n    = mv_neg;
                end
            end
            OP_SET: begin
                nxt_data = {{(DATA_W-1){1'b0}}, hit};
                nxt_wr   = 1'b1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            dst_o <= '0;
            wr_o  <= 1'b0;
            z_o   <= 1'b0;
            n_o   <= 1'b0;
        end else begin
            dst_o <= nxt_data;
            wr_o  <= nxt_wr;
            z_o   <= nxt_z;
            n_o   <= nxt_n;
        end
    end
endmodule

// File: rtl/cmov_set_chk.sv
module cmov_set_chk #(
    parameter int DATA_W = 64,
    parameter int SIZE_W = 3
) (
    input logic              clk_i,
    input logic              rst_i,
    input logic [DATA_W-1:0] dst_i,
    input logic [SIZE_W-1:0] size_i,
    input logic [1:0]        op_i,
    input logic              flag_n_i,
    input logic              flag_z_i,
    input logic [DATA_W-1:0] dst_o,
    input logic              wr_o,
    input logic              z_o,
    input logic              n_o
);
    AST_SET_IS_BINARY: assert property (@(posedge clk_i) disable iff (rst_i)
        (op_i == 2'b10) |=> (wr_o && dst_o[DATA_W-1:1] == '0)); // R7

    AST_SET_KEEPS_FLAGS: assert property (@(posedge clk_i) disable iff (rst_i)
        (op_i == 2'b10) |=> (z_o == $past(flag_z_i) && n_o == $past(flag_n_i))); // R7

    AST_MOVE_ALWAYS_WRITES: assert property (@(posedge clk_i) disable iff (rst_i)
        (op_i == 2'b00) |=> wr_o); // R6

    AST_NO_WRITE_PASSES: assert property (@(posedge clk_i) disable iff (rst_i)
        1'b1 |=> (wr_o || (dst_o == $past(dst_i) && z_o == $past(flag_z_i)
                           && n_o == $past(flag_n_i)))); // R2

    AST_NONE_NEVER_WRITES: assert property (@(posedge clk_i) disable iff (rst_i)
        (op_i == 2'b11) |=> !wr_o); // R8

    AST_MOVE_ZERO_FLAG: assert property (@(posedge clk_i) disable iff (rst_i)
        (op_i == 2'b00 || op_i == 2'b01) |=> (!wr_o || z_o == (dst_o == '0))); // R4

    AST_BYTE0_MOVE_CLEARS: assert property (@(posedge clk_i) disable iff (rst_i)
        (op_i == 2'b00 && size_i == '0) |=> (dst_o[DATA_W-1:8] == '0 && n_o == dst_o[7])); // R3
endmodule

bind cmov_set_unit cmov_set_chk #(.DATA_W(DATA_W), .SIZE_W(SIZE_W)) u_chk (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .dst_i    (dst_i),
    .size_i   (size_i),
    .op_i     (op_i),
    .flag_n_i (flag_n_i),
    .flag_z_i (flag_z_i),
    .dst_o    (dst_o),
    .wr_o     (wr_o),
    .z_o      (z_o),
    .n_o      (n_o)
);

// File: tb/sim_cmov_set_unit.sv
module sim_cmov_set_unit;
    localparam int W = 64;

    logic          clk = 1'b0;
    logic          rst;
    logic [W-1:0]  src, dst;
    logic [2:0]    size;
    logic [1:0]    op;
    logic [2:0]    cc;
    logic          fn, fc, fz, fv;
    logic [W-1:0]  dst_o;
    logic          wr_o, z_o, n_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    cmov_set_unit #(.DATA_W(W), .SIZE_W(3)) u0 (
        .clk_i(clk), .rst_i(rst), .src_i(src), .dst_i(dst), .size_i(size),
        .op_i(op), .cond_i(cc), .flag_n_i(fn), .flag_c_i(fc), .flag_z_i(fz),
        .flag_v_i(fv), .dst_o(dst_o), .wr_o(wr_o), .z_o(z_o), .n_o(n_o)
    );

    function automatic logic exp_cond(logic [2:0] c, logic n, logic cy, logic z, logic v);
        logic f;
        case (c[2:1])
            2'd0: f = n;
            2'd1: f = cy;
            2'd2: f = z;
            default: f = v;
        endcase
        return f ^ c[0];
    endfunction

    function automatic logic [W-1:0] exp_mask(logic [W-1:0] s, int sz);
        logic [W-1:0] r = '0;
        for (int i = 0; i <= sz; i++) r[i*8 +: 8] = s[i*8 +: 8];
        return r;
    endfunction

    task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic apply_and_check(string tag);
        logic          hit, moved;
        logic [W-1:0]  e_d;
        logic          e_w, e_z, e_n;
        int            sz;
        hit = exp_cond(cc, fn, fc, fz, fv);
        sz  = (int'(size) > 7) ? 7 : int'(size);
        e_d = dst; e_w = 1'b0; e_z = fz; e_n = fn;
        moved = (op == 2'b00) || (op == 2'b01 && hit);
        if (moved) begin
            e_d = exp_mask(src, sz);
            e_w = 1'b1;
            e_z = (e_d == '0);
            e_n = e_d[(sz+1)*8-1];
        end else if (op == 2'b10) begin
            e_d = {{(W-1){1'b0}}, hit};
            e_w = 1'b1;
        end
        @(posedge clk);
        @(negedge clk);
        check({tag, " data"}, dst_o, e_d);
        check({tag, " strobe"}, W'(wr_o), W'(e_w));
        check({tag, " zflag"}, W'(z_o), W'(e_z));
        check({tag, " nflag"}, W'(n_o), W'(e_n));
    endtask

    task automatic drive(logic [W-1:0] s, logic [W-1:0] d, logic [2:0] sz,
                         logic [1:0] o, logic [2:0] c, logic [3:0] f);
        src = s; dst = d; size = sz; op = o; cc = c;
        {fn, fc, fz, fv} = f;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] seed;
        rst = 1'b1;
        drive('1, '1, 3'd7, 2'b00, 3'd0, 4'hF);
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R9 reset state
        check("R9 reset data", dst_o, '0);
        check("R9 reset strobe", W'(wr_o), '0);
        check("R9 reset flags", W'({z_o, n_o}), '0);
        rst = 1'b0;

        // R3 R5: one byte, sign at bit 7
        drive(64'hFFFF_FFFF_FFFF_FF80, 64'h1234, 3'd0, 2'b00, 3'd0, 4'h0);
        apply_and_check("R3 R5 byte0 neg");
        // R4: masked result zero though source nonzero
        drive(64'hAB00_0000_0000_0100, 64'h1, 3'd0, 2'b00, 3'd0, 4'h0);
        apply_and_check("R4 zero after mask");
        // R3: full width
        drive(64'h8000_0000_0000_0001, 64'h0, 3'd7, 2'b00, 3'd0, 4'h0);
        apply_and_check("R3 R5 full width");
        // R6: move with all flags making conditions false still writes
        drive(64'h0000_0000_0012_3456, 64'h9, 3'd2, 2'b00, 3'd1, 4'hF);
        apply_and_check("R6 unconditional");
        // R1 R2 R7: every condition, each flag pattern, cmove and set
        for (int c = 0; c < 8; c++) begin
            for (int f = 0; f < 16; f++) begin
                drive(64'h00C3_5A00_FF00_8001, 64'hDEAD_BEEF_0000_1111, 3'd3, 2'b01, 3'(c), 4'(f));
                apply_and_check("R1 R2 cmove cond");
                drive(64'h5, 64'hDEAD_BEEF_0000_1111, 3'd3, 2'b10, 3'(c), 4'(f));
                apply_and_check("R1 R7 set cond");
            end
        end
        // R8: reserved op
        drive(64'h77, 64'hCAFE, 3'd1, 2'b11, 3'd0, 4'hA);
        apply_and_check("R8 none op");

        // random mix, R1..R8
        seed = $urandom(32'd20240611);
        for (int i = 0; i < 3000; i++) begin
            drive({$urandom(), $urandom()}, {$urandom(), $urandom()},
                  3'($urandom()), 2'($urandom()), 3'($urandom()), 4'($urandom()));
            if (($urandom() & 7) == 0) src = src & 64'h0000_FFFF_0000_0000;
            apply_and_check("R3 R4 R5 random");
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule